// File: doc/BRIEF.md
# Timed External Memory Bus Controller

This block turns single read and write commands from an on-chip memory-mapped master into a timed strobe sequence for an asynchronous off-chip SRAM, flash or peripheral. It latches the command and asks a shared pin arbiter for the bus. Once granted, it drives chip select, address, byte enables and, for writes, the write data with its output enable. After a setup phase it pulses the read or write strobe for a set width. A write then keeps the bus driven for a hold phase. The master is stalled through a wait output until the final cycle of the access. Read data is sampled on the edge that ends the read strobe and is returned with a one-cycle valid pulse.

The phase lengths are given in nanoseconds and turned into clock cycles at elaboration. Each strobe-type output has its own polarity parameter. A lane-gated mode merges byte enables and the write strobe into one set of per-byte write enables. A read-to-write turnaround guard holds back a write that follows a read too closely.

The controller is one state machine with five states. IDLE moves to REQ when a command is accepted. REQ moves to SETUP when grant is seen and the setup count is non-zero, and straight to STROBE otherwise. SETUP moves to STROBE when its count expires. STROBE moves to HOLD at the end of a write that has a non-zero hold count, and to IDLE in every other case. HOLD moves to IDLE when its count expires.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While reset is asserted and right after it, chip select, read strobe, write strobe and data output enable are at their inactive levels, and `mm_wait`, `arb_req`, `ext_start` and `mm_rvalid` are low.
- R2: An accepted command raises `arb_req`. Chip select, address and strobes stay idle until `arb_gnt` is sampled high, and the first driven cycle follows that edge. `ext_addr` and `ext_dout` are zero in every undriven cycle.
- R3: Chip select, address, byte enables and write data are driven for the setup count of cycles before the strobe. With a zero setup count the strobe starts in the first driven cycle.
- R4: The read strobe lasts the read-wait count of cycles and the write strobe the write-wait count. A zero count still gives a one-cycle strobe.
- R5: Read data is sampled from `ext_din` on the clock edge that ends the read strobe. It appears on `mm_rdata` in the next cycle together with a one-cycle `mm_rvalid` pulse.
- R6: After a write strobe, chip select, address, write data and `ext_doe` stay active for the hold count of cycles. A read ends with its strobe. `ext_doe` is active only during the driven cycles of writes.
- R7: `mm_wait` is high from the cycle a command appears until the last cycle of its access, where it is low. `arb_req` is also low in that last cycle.
- R8: Each nanosecond time becomes ceil(time / clock period) cycles. For example, 12 ns at a 5 ns period is 3 cycles.
- R9: In lane-gated mode, `ext_wbe[i]` is active exactly when byte enable i is set and the write strobe is active. `ext_wr` and `ext_be` then stay inactive.
- R10: Each of chip select, read strobe, write strobe, byte enables, output enable and lane write enables is inverted when its active-low parameter is set.
- R11: `ext_start` is high for exactly the first driven cycle of every access.
- R12: The turnaround gap is the larger of the turnaround parameter and the read latency plus two. A write is not accepted until that many clock edges after the edge that accepted the preceding read. Until then `mm_wait` stays high.
- R13: If read and write are requested together, the read is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mm_rd | input | 1 | Read command |
| mm_wr | input | 1 | Write command |
| mm_addr | input | ADDR_W | Command byte address |
| mm_wdata | input | DATA_W | Write data |
| mm_be | input | DATA_W/8 | Byte enables |
| mm_wait | output | 1 | Stall to the master |
| mm_rdata | output | DATA_W | Read data |
| mm_rvalid | output | 1 | Read data valid pulse |
| arb_req | output | 1 | Bus request to pin arbiter |
| arb_gnt | input | 1 | Bus grant from pin arbiter |
| ext_cs | output | 1 | Chip select |
| ext_addr | output | ADDR_W | External address |
| ext_dout | output | DATA_W | External write data |
| ext_doe | output | 1 | Write data output enable |
| ext_din | input | DATA_W | External read data |
| ext_rd | output | 1 | Read strobe |
| ext_wr | output | 1 | Write strobe |
| ext_be | output | DATA_W/8 | Byte enables |
| ext_wbe | output | DATA_W/8 | Lane-gated write enables |
| ext_start | output | 1 | First-cycle marker of an access |

## Verification
Pins respond one clock edge after the grant edge. Strobes follow after exactly the setup count. The read value is due one cycle after the edge that closes the read strobe. `mm_wait` and `arb_req` fall in the same cycle the last strobe or hold cycle starts. The bench keeps a per-cycle model that counts these delays from acceptance and from grant, and compares every output at the falling edge. Inputs change just after rising edges, so each comparison sees settled values. Two configurations run: one with multi-cycle phases, active-high pins and a binding turnaround gap, and one with zero setup and hold, active-low pins and lane-gated writes.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } ebc_state_e;

    // round a time in ns up to whole clock periods
    function automatic int ns_to_cyc(input int t_ns, input int period_ns);
        return (t_ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ebc_turn_guard.sv
module ebc_turn_guard #(
    parameter int GAP = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_accept,
    output logic wr_blocked
);
    localparam int TW = $clog2(GAP + 1);
    localparam logic [TW-1:0] LOAD = TW'(GAP - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rd_accept) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign wr_blocked = (cnt_q != '0);

    // R12: a read acceptance always closes the write window
    a_r12_block_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_accept |=> wr_blocked);

    // R12: the gap only shrinks by one per cycle
    a_r12_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_blocked && !rd_accept) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ebc_phase_fsm.sv
module ebc_phase_fsm
    import ebc_pkg::*;
#(
    parameter int SETUP_C = 3,
    parameter int RDW_C   = 2,
    parameter int WRW_C   = 1,
    parameter int HOLD_C  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_rd,
    input  logic       cmd_wr,
    input  logic       wr_blocked,
    input  logic       arb_gnt,
    output logic       accept,
    output ebc_state_e state_o,
    output logic       is_wr,
    output logic       pin_on,
    output logic       strobe_rd,
    output logic       strobe_wr,
    output logic       first_pin,
    output logic       last_cyc,
    output logic       capture
);
    localparam int RDW_E  = imax(RDW_C, 1);
    localparam int WRW_E  = imax(WRW_C, 1);
    localparam int PH_MAX = imax(imax(SETUP_C, HOLD_C), imax(RDW_E, WRW_E));
    localparam int CW     = imax($clog2(PH_MAX + 1), 1);
    localparam bit HAS_SETUP = (SETUP_C > 0);
    localparam bit HAS_HOLD  = (HOLD_C > 0);
    localparam logic [CW-1:0] SETUP_LD = CW'(imax(SETUP_C, 1) - 1);
    localparam logic [CW-1:0] HOLD_LD  = CW'(imax(HOLD_C, 1) - 1);
    localparam logic [CW-1:0] RD_LD    = CW'(RDW_E - 1);
    localparam logic [CW-1:0] WR_LD    = CW'(WRW_E - 1);

    ebc_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          wr_q, wr_d;
    logic          first_q, first_d;
    logic          hold_used;
    logic [CW-1:0] strobe_ld;

    assign hold_used = wr_q && HAS_HOLD;
    assign strobe_ld = wr_q ? WR_LD : RD_LD;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            wr_q    <= wr_d;
            first_q <= first_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wr_d    = wr_q;
        first_d = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_REQ;
                    wr_d    = !cmd_rd;
                end
            end
            ST_REQ: begin
                if (arb_gnt) begin
                    first_d = 1'b1;
                    if (HAS_SETUP) begin
                        state_d = ST_SETUP;
                        cnt_d   = SETUP_LD;
                    end else begin
                        state_d = ST_STROBE;
                        cnt_d   = strobe_ld;
                    end
                end
            end
            ST_SETUP: begin
                if (cnt_q == '0) begin
                    state_d = ST_STROBE;
                    cnt_d   = strobe_ld;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_STROBE: begin
                if (cnt_q == '0) begin
                    if (hold_used) begin
                        state_d = ST_HOLD;
                        cnt_d   = HOLD_LD;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept    = (state_q == ST_IDLE) && (cmd_rd || (cmd_wr && !wr_blocked));
        state_o   = state_q;
        is_wr     = wr_q;
        pin_on    = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
        strobe_rd = (state_q == ST_STROBE) && !wr_q;
        strobe_wr = (state_q == ST_STROBE) && wr_q;
        first_pin = first_q;
        capture   = strobe_rd && (cnt_q == '0);
        last_cyc  = ((state_q == ST_STROBE) && (cnt_q == '0) && !hold_used)
                 || ((state_q == ST_HOLD) && (cnt_q == '0));
    end

    // R2: no pin activity without the bus grant
    a_r2_pins_need_grant: assert property (@(posedge clk) disable iff (!rst_n)
        pin_on |-> arb_gnt);

    // R11: begin marker is a single cycle
    a_r11_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        first_pin |=> !first_pin);

    // R7: the last cycle always hands back to idle
    a_r7_last_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        last_cyc |=> (state_q == ST_IDLE));

    if (HAS_SETUP) begin : g_a_setup
        // R3: a strobe never starts on an undriven bus
        a_r3_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(strobe_rd || strobe_wr) |-> $past(pin_on));
    end

    if (HAS_HOLD) begin : g_a_hold
        // R6: the bus stays driven right after a write strobe
        a_r6_hold_after_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(strobe_wr) |-> pin_on);
    end

endmodule

// File: rtl/ebc_pin_drive.sv
module ebc_pin_drive #(
    parameter int BE_W     = 2,
    parameter bit RD_LOW   = 1'b0,
    parameter bit WR_LOW   = 1'b0,
    parameter bit CS_LOW   = 1'b0,
    parameter bit BE_LOW   = 1'b0,
    parameter bit OE_LOW   = 1'b0,
    parameter bit WBE_LOW  = 1'b0,
    parameter bit WBE_MODE = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pin_on,
    input  logic            strobe_rd,
    input  logic            strobe_wr,
    input  logic            is_wr,
    input  logic [BE_W-1:0] be_in,
    output logic            ext_cs,
    output logic            ext_rd,
    output logic            ext_wr,
    output logic            ext_doe,
    output logic [BE_W-1:0] ext_be,
    output logic [BE_W-1:0] ext_wbe
);
    logic            wr_log;
    logic [BE_W-1:0] be_log;
    logic [BE_W-1:0] wbe_log;

    if (WBE_MODE) begin : g_lane_gated
        assign wr_log  = 1'b0;
        assign be_log  = '0;
        assign wbe_log = strobe_wr ? be_in : '0;
    end else begin : g_split
        assign wr_log  = strobe_wr;
        assign be_log  = pin_on ? be_in : '0;
        assign wbe_log = '0;
    end

    assign ext_cs  = pin_on ^ CS_LOW;
    assign ext_rd  = strobe_rd ^ RD_LOW;
    assign ext_wr  = wr_log ^ WR_LOW;
    assign ext_doe = (pin_on && is_wr) ^ OE_LOW;

    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        assign ext_be[i]  = be_log[i] ^ BE_LOW;
        assign ext_wbe[i] = wbe_log[i] ^ WBE_LOW;
    end

    // R9: a lane write enable only appears inside a write strobe
    a_r9_lane_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (|wbe_log) |-> (strobe_wr && pin_on));

endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int CLK_NS     = 5,
    parameter int SETUP_NS   = 12,
    parameter int RD_WAIT_NS = 8,
    parameter int WR_WAIT_NS = 5,
    parameter int HOLD_NS    = 4,
    parameter int TURN_CYC   = 12,
    parameter int RD_LAT_CYC = 2,
    parameter bit RD_LOW     = 1'b0,
    parameter bit WR_LOW     = 1'b0,
    parameter bit CS_LOW     = 1'b0,
    parameter bit BE_LOW     = 1'b0,
    parameter bit OE_LOW     = 1'b0,
    parameter bit WBE_LOW    = 1'b0,
    parameter bit WBE_MODE   = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mm_rd,
    input  logic                mm_wr,
    input  logic [ADDR_W-1:0]   mm_addr,
    input  logic [DATA_W-1:0]   mm_wdata,
    input  logic [DATA_W/8-1:0] mm_be,
    output logic                mm_wait,
    output logic [DATA_W-1:0]   mm_rdata,
    output logic                mm_rvalid,
    output logic                arb_req,
    input  logic                arb_gnt,
    output logic                ext_cs,
    output logic [ADDR_W-1:0]   ext_addr,
    output logic [DATA_W-1:0]   ext_dout,
    output logic                ext_doe,
    input  logic [DATA_W-1:0]   ext_din,
    output logic                ext_rd,
    output logic                ext_wr,
    output logic [DATA_W/8-1:0] ext_be,
    output logic [DATA_W/8-1:0] ext_wbe,
    output logic                ext_start
);
    localparam int BE_W    = DATA_W / 8;
    localparam int SETUP_C = ns_to_cyc(SETUP_NS, CLK_NS);
    localparam int RDW_C   = ns_to_cyc(RD_WAIT_NS, CLK_NS);
    localparam int WRW_C   = ns_to_cyc(WR_WAIT_NS, CLK_NS);
    localparam int HOLD_C  = ns_to_cyc(HOLD_NS, CLK_NS);
    localparam int GAP     = imax(TURN_CYC, RD_LAT_CYC + 2);

    ebc_state_e        state;
    logic              accept, is_wr, pin_on, strobe_rd, strobe_wr;
    logic              first_pin, last_cyc, capture, wr_blocked;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q, rdata_q;
    logic [BE_W-1:0]   be_q;
    logic              rvalid_q;

    ebc_turn_guard #(.GAP(GAP)) u_turn (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_accept  (accept && mm_rd),
        .wr_blocked (wr_blocked)
    );

    ebc_phase_fsm #(
        .SETUP_C (SETUP_C),
        .RDW_C   (RDW_C),
        .WRW_C   (WRW_C),
        .HOLD_C  (HOLD_C)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_rd     (mm_rd),
        .cmd_wr     (mm_wr),
        .wr_blocked (wr_blocked),
        .arb_gnt    (arb_gnt),
        .accept     (accept),
        .state_o    (state),
        .is_wr      (is_wr),
        .pin_on     (pin_on),
        .strobe_rd  (strobe_rd),
        .strobe_wr  (strobe_wr),
        .first_pin  (first_pin),
        .last_cyc   (last_cyc),
        .capture    (capture)
    );

    ebc_pin_drive #(
        .BE_W     (BE_W),
        .RD_LOW   (RD_LOW),
        .WR_LOW   (WR_LOW),
        .CS_LOW   (CS_LOW),
        .BE_LOW   (BE_LOW),
        .OE_LOW   (OE_LOW),
        .WBE_LOW  (WBE_LOW),
        .WBE_MODE (WBE_MODE)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_on    (pin_on),
        .strobe_rd (strobe_rd),
        .strobe_wr (strobe_wr),
        .is_wr     (is_wr),
        .be_in     (be_q),
        .ext_cs    (ext_cs),
        .ext_rd    (ext_rd),
        .ext_wr    (ext_wr),
        .ext_doe   (ext_doe),
        .ext_be    (ext_be),
        .ext_wbe   (ext_wbe)
    );

    // command latch and read return
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            data_q   <= '0;
            be_q     <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q <= mm_addr;
                data_q <= mm_wdata;
                be_q   <= mm_be;
            end
            if (capture) begin
                rdata_q <= ext_din;
            end
            rvalid_q <= capture;
        end
    end

    always_comb begin
        if (state == ST_IDLE) begin
            mm_wait = mm_rd || mm_wr;
            arb_req = 1'b0;
        end else begin
            mm_wait = !last_cyc;
            arb_req = !last_cyc;
        end
        ext_addr  = pin_on ? addr_q : '0;
        ext_dout  = (pin_on && is_wr) ? data_q : '0;
        ext_start = first_pin;
        mm_rdata  = rdata_q;
        mm_rvalid = rvalid_q;
    end

    // R5: read return is a single-cycle pulse
    a_r5_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
        mm_rvalid |=> !mm_rvalid);

    // R7: releasing the master means the access is over
    a_r7_release_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !mm_wait) |=> (state == ST_IDLE));

endmodule

// File: tb/test_ext_bus_ctrl.sv
`timescale 1ns/1ps

module ebc_harness #(
    parameter int SETUP_NS   = 12,
    parameter int RD_WAIT_NS = 8,
    parameter int WR_WAIT_NS = 5,
    parameter int HOLD_NS    = 4,
    parameter int TURN_CYC   = 12,
    parameter int RD_LAT_CYC = 2,
    parameter bit LOW        = 1'b0,
    parameter bit WBE_MODE   = 1'b0,
    parameter int M_S        = 3,
    parameter int M_WR       = 2,
    parameter int M_WW       = 1,
    parameter int M_H        = 1,
    parameter int M_GAP      = 12
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_bad,
    output bit   done
);
    logic        mm_rd = 0, mm_wr = 0;
    logic [15:0] mm_addr = 0, mm_wdata = 0;
    logic [1:0]  mm_be = 0;
    logic        mm_wait, mm_rvalid, arb_req, ext_cs, ext_doe, ext_rd, ext_wr, ext_start;
    logic [15:0] mm_rdata, ext_addr, ext_dout, ext_din;
    logic [1:0]  ext_be, ext_wbe;
    logic        gnt = 0;
    int          delay_cfg = 0;

    function automatic logic [15:0] fdin(input logic [15:0] a);
        return {a[7:0] ^ 8'hC3, a[15:8] + 8'h11};
    endfunction

    assign ext_din = fdin(ext_addr);

    ext_bus_ctrl #(
        .CLK_NS(5), .SETUP_NS(SETUP_NS), .RD_WAIT_NS(RD_WAIT_NS),
        .WR_WAIT_NS(WR_WAIT_NS), .HOLD_NS(HOLD_NS), .TURN_CYC(TURN_CYC),
        .RD_LAT_CYC(RD_LAT_CYC), .RD_LOW(LOW), .WR_LOW(LOW), .CS_LOW(LOW),
        .BE_LOW(LOW), .OE_LOW(LOW), .WBE_LOW(LOW), .WBE_MODE(WBE_MODE)
    ) i_ext_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .mm_rd(mm_rd), .mm_wr(mm_wr),
        .mm_addr(mm_addr), .mm_wdata(mm_wdata), .mm_be(mm_be),
        .mm_wait(mm_wait), .mm_rdata(mm_rdata), .mm_rvalid(mm_rvalid),
        .arb_req(arb_req), .arb_gnt(gnt), .ext_cs(ext_cs), .ext_addr(ext_addr),
        .ext_dout(ext_dout), .ext_doe(ext_doe), .ext_din(ext_din),
        .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_be(ext_be), .ext_wbe(ext_wbe),
        .ext_start(ext_start)
    );

    // behavioural reference: phase 0 idle, 1 waiting grant, 2 driving
    int          m_ph = 0, t = 0, cyc = 0, rd_cyc = -1000, req_age = 0;
    logic        m_wr = 0;
    logic [15:0] m_addr = 0, m_data = 0, m_rdexp = 0;
    logic [1:0]  m_be = 0;
    bit          m_rv = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; t = 0; m_rv = 0; rd_cyc = -1000; cyc = 0; req_age = 0;
            gnt <= 1'b0;
        end else begin
            cyc++;
            m_rv = 0;
            case (m_ph)
                0: if (mm_rd || (mm_wr && (cyc - rd_cyc) >= M_GAP)) begin
                       m_wr = !mm_rd;  // R13 read wins
                       m_addr = mm_addr; m_data = mm_wdata; m_be = mm_be;
                       if (mm_rd) rd_cyc = cyc;
                       m_ph = 1;
                   end
                1: if (gnt) begin m_ph = 2; t = 0; end
                default: begin
                    if (!m_wr && t == M_S + M_WR - 1) begin
                        m_rdexp = fdin(m_addr);
                        m_rv = 1;
                    end
                    t++;
                    if (t == M_S + (m_wr ? M_WW : M_WR) + (m_wr ? M_H : 0)) m_ph = 0;
                end
            endcase
            gnt <= arb_req && (req_age >= delay_cfg);
            req_age = arb_req ? req_age + 1 : 0;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h cycle %0d", tag, act, exp, cyc);
        end
    endtask

    bit act_on, last, str, in_idle_blk;
    int w, tot;
    initial begin n_chk = 0; n_bad = 0; end

    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1 cs", ext_cs, LOW);
            chk("R1 rd", ext_rd, LOW);
            chk("R1 wr", ext_wr, LOW);
            chk("R1 doe", ext_doe, LOW);
            chk("R1 wait", mm_wait, 0);
            chk("R1 req", arb_req, 0);
            chk("R1 start", ext_start, 0);
            chk("R1 rvalid", mm_rvalid, 0);
        end else begin
            act_on = (m_ph == 2);
            w   = m_wr ? M_WW : M_WR;
            tot = M_S + w + (m_wr ? M_H : 0);
            last = act_on && (t == tot - 1);
            str  = act_on && (t >= M_S) && (t < M_S + w);
            in_idle_blk = (m_ph == 0) && mm_wr && !mm_rd;
            chk("R3 R10 cs", ext_cs, act_on ^ LOW);
            chk("R2 addr", ext_addr, act_on ? m_addr : 16'h0);
            chk("R6 dout", ext_dout, (act_on && m_wr) ? m_data : 16'h0);
            chk("R6 R10 doe", ext_doe, (act_on && m_wr) ^ LOW);
            chk("R4 R8 R10 rd", ext_rd, (str && !m_wr) ^ LOW);
            chk("R4 R9 wr", ext_wr, (str && m_wr && !WBE_MODE) ^ LOW);
            chk("R9 R10 be", ext_be, ((act_on && !WBE_MODE) ? m_be : 2'b00) ^ {2{LOW}});
            chk("R9 wbe", ext_wbe, ((str && m_wr && WBE_MODE) ? m_be : 2'b00) ^ {2{LOW}});
            chk("R11 start", ext_start, act_on && (t == 0));
            chk("R2 req", arb_req, (m_ph != 0) && !last);
            if (in_idle_blk && (cyc + 1 - rd_cyc) < M_GAP)
                chk("R12 wait", mm_wait, 1);
            else
                chk("R7 wait", mm_wait, (m_ph == 0) ? (mm_rd || mm_wr) : !last);
            chk("R5 rvalid", mm_rvalid, m_rv);
            if (m_rv) chk("R5 rdata", mm_rdata, m_rdexp);
        end
    end

    task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          input logic [1:0] be, input bit both = 0);
        @(posedge clk); #1;
        mm_rd = !wr || both; mm_wr = wr; mm_addr = a; mm_wdata = d; mm_be = be;
        do @(negedge clk); while (mm_wait);
        @(posedge clk); #1;
        mm_rd = 0; mm_wr = 0;
    endtask

    initial begin
        done = 0;
        wait (rst_n);
        access(0, 16'h0012, 16'h0000, 2'b11);
        access(1, 16'h0034, 16'hBEEF, 2'b10);   // R12 follows a read
        access(1, 16'h0036, 16'h1234, 2'b01);
        access(0, 16'h0034, 16'hFFFF, 2'b01);
        delay_cfg = 3;                            // R2 late grant
        access(0, 16'h00A5, 16'h0000, 2'b10);
        access(1, 16'h00A6, 16'h5A5A, 2'b11);
        delay_cfg = 0;
        access(1, 16'h7FFE, 16'hC0DE, 2'b11, 1);  // R13 both asserted
        access(1, 16'h0100, 16'h0F0F, 2'b10);
        repeat (6) @(posedge clk);
        done = 1;
    end
endmodule

module test_ext_bus_ctrl;
    logic clk = 0;
    logic rst_n = 0;
    int   chk_a, bad_a, chk_b, bad_b, cyc = 0, wd_bad = 0;
    bit   done_a, done_b;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    ebc_harness #(
        .SETUP_NS(12), .RD_WAIT_NS(8), .WR_WAIT_NS(5), .HOLD_NS(4),
        .TURN_CYC(12), .RD_LAT_CYC(2), .LOW(1'b0), .WBE_MODE(1'b0),
        .M_S(3), .M_WR(2), .M_WW(1), .M_H(1), .M_GAP(12)
    ) h_a (.clk(clk), .rst_n(rst_n), .n_chk(chk_a), .n_bad(bad_a), .done(done_a));

    ebc_harness #(
        .SETUP_NS(0), .RD_WAIT_NS(0), .WR_WAIT_NS(7), .HOLD_NS(0),
        .TURN_CYC(0), .RD_LAT_CYC(0), .LOW(1'b1), .WBE_MODE(1'b1),
        .M_S(0), .M_WR(1), .M_WW(2), .M_H(0), .M_GAP(2)
    ) h_b (.clk(clk), .rst_n(rst_n), .n_chk(chk_b), .n_bad(bad_b), .done(done_b));

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        while (!(done_a && done_b) && cyc < 20000) @(posedge clk);
        if (!(done_a && done_b)) begin
            wd_bad = 1;
            $display("FAIL watchdog: actual cycle %0d expected finish before 20000", cyc);
        end
        $display("test done: total=%0d bad=%0d", chk_a + chk_b + wd_bad, bad_a + bad_b + wd_bad);
        $finish;
    end
endmodule